// File: doc/BRIEF.md
# Packed Lane Narrowing and Interleave Unit

This block rearranges the integer lanes of two 64-bit operands in one cycle. It has two families of operations. Narrowing takes the wider elements of both operands, clamps each one into the range of an element half as wide, and concatenates the results. Interleaving takes either the lower halves or the upper halves of both operands and alternates their elements, at byte, word or doubleword size.

Operand A is the destination-side operand and operand B is the source-side operand. The operation is picked by a 4-bit code that is sampled together with an input strobe. On the next clock edge the result is placed in an output register, and a one-cycle valid pulse marks it. A code outside the defined set gives an all-zero result and raises an error flag. The control decodes the code into a small strobe bundle, and the datapath uses that bundle to build and hold the result.

Top module: `lane_mix_unit`

## Requirements
- R1: Code 0 narrows signed 16-bit words to bytes and clamps each value to -128..127. Words 0..3 of A go to bytes 0..3 of the result, and words 0..3 of B go to bytes 4..7.
- R2: Code 1 narrows signed 32-bit doublewords to 16-bit words and clamps each value to -32768..32767. Doublewords 0..1 of A go to words 0..1 of the result, and doublewords 0..1 of B go to words 2..3.
- R3: Code 2 narrows signed 16-bit words to unsigned bytes. A negative word gives 0, a word above 255 gives 255, and the lane placement is the same as in R1.
- R4: Code 4 interleaves the low four bytes of both operands from bit 0 upward in the order A0, B0, A1, B1, A2, B2, A3, B3.
- R5: Code 5 interleaves the low two words in the order A0, B0, A1, B1. Code 6 interleaves the low doublewords in the order A0, B0.
- R6: Codes 8, 9 and 10 do the same as codes 4, 5 and 6 but take the upper-half elements, starting with the lowest upper element of A.
- R7: outValid is high exactly in the cycle after a cycle with inValid high, and outData holds that operation's result during that cycle.
- R8: While inValid is low, outData and outErr keep their last values.
- R9: Any code other than 0, 1, 2, 4, 5, 6, 8, 9 or 10 gives outData of zero and outErr of 1. A defined code gives outErr of 0.
- R10: A synchronous active-high reset clears outValid, outData and outErr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Operation strobe |
| opCode | input | 4 | Operation select |
| opA | input | 64 | Destination-side operand |
| opB | input | 64 | Source-side operand |
| outValid | output | 1 | Result valid pulse |
| outData | output | 64 | Registered result |
| outErr | output | 1 | Unsupported code flag |

## Verification
The assertions assume that opCode, opA and opB are settled whenever inValid is high, and that every input is at a known level once reset is released. The bench changes inputs only on falling clock edges and holds them until the next falling edge. It drives zeros during reset. In the hold scenario it moves the operands and the code while the strobe is low, which shows that only the strobe starts a capture.

// File: rtl/lane_mix_pkg.sv
package lane_mix_pkg;

  typedef enum logic [3:0] {
    OP_NARROW_SB = 4'd0,
    OP_NARROW_SW = 4'd1,
    OP_NARROW_UB = 4'd2,
    OP_MIXLO_B   = 4'd4,
    OP_MIXLO_W   = 4'd5,
    OP_MIXLO_D   = 4'd6,
    OP_MIXHI_B   = 4'd8,
    OP_MIXHI_W   = 4'd9,
    OP_MIXHI_D   = 4'd10
  } mixOp_t;

  typedef enum logic [1:0] {
    SEL_NSB = 2'd0,
    SEL_NUB = 2'd1,
    SEL_NSW = 2'd2,
    SEL_MIX = 2'd3
  } resSel_t;

  typedef struct packed {
    logic    load;
    logic    bad;
    resSel_t sel;
    logic    mixHigh;
    logic [1:0] gran;
  } mixStrobe_t;

  function automatic logic [7:0] clampSByte(input logic [15:0] w);
    if (!w[15] && (w[14:7] != 8'h00))      return 8'h7f;
    else if (w[15] && (w[14:7] != 8'hff))  return 8'h80;
    else                                   return w[7:0];
  endfunction

  function automatic logic [7:0] clampUByte(input logic [15:0] w);
    if (w[15])                 return 8'h00;
    else if (w[14:8] != 7'h0)  return 8'hff;
    else                       return w[7:0];
  endfunction

  function automatic logic [15:0] clampSWord(input logic [31:0] d);
    if (!d[31] && (d[30:15] != 16'h0000))     return 16'h7fff;
    else if (d[31] && (d[30:15] != 16'hffff)) return 16'h8000;
    else                                      return d[15:0];
  endfunction

endpackage

// File: rtl/lane_mix_ctrl.sv
module lane_mix_ctrl
  import lane_mix_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       inValid,
  input  logic [3:0] opCode,
  output mixStrobe_t stb,
  output logic       outValid
);

  always_comb begin
    stb         = '0;
    stb.load    = inValid;
    stb.sel     = SEL_MIX;
    case (opCode)
      OP_NARROW_SB: stb.sel = SEL_NSB;
      OP_NARROW_SW: stb.sel = SEL_NSW;
      OP_NARROW_UB: stb.sel = SEL_NUB;
      OP_MIXLO_B:   stb.gran = 2'd0;
      OP_MIXLO_W:   stb.gran = 2'd1;
      OP_MIXLO_D:   stb.gran = 2'd2;
      OP_MIXHI_B: begin stb.gran = 2'd0; stb.mixHigh = 1'b1; end
      OP_MIXHI_W: begin stb.gran = 2'd1; stb.mixHigh = 1'b1; end
      OP_MIXHI_D: begin stb.gran = 2'd2; stb.mixHigh = 1'b1; end
      default:      stb.bad = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) outValid <= 1'b0;
    else     outValid <= inValid;
  end

  // R7
  valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
    inValid |=> outValid);

  // R7
  valid_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> !outValid);

endmodule

// File: rtl/lane_mix_dp.sv
module lane_mix_dp
  import lane_mix_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  mixStrobe_t        stb,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  output logic [DATA_W-1:0] outData,
  output logic              outErr
);

  localparam int HALF_W  = DATA_W / 2;
  localparam int N_WORD  = DATA_W / 16;
  localparam int N_DWORD = DATA_W / 32;
  localparam int N_GRAN  = 3;

  wire [DATA_W-1:0] nsb;
  wire [DATA_W-1:0] nub;
  wire [DATA_W-1:0] nsw;
  wire [DATA_W-1:0] mixLo [N_GRAN];
  wire [DATA_W-1:0] mixHi [N_GRAN];
  logic [DATA_W-1:0] result;

  for (genvar i = 0; i < N_WORD; i++) begin : g_word
    assign nsb[i*8 +: 8]          = clampSByte(opA[i*16 +: 16]);
    assign nsb[HALF_W+i*8 +: 8]   = clampSByte(opB[i*16 +: 16]);
    assign nub[i*8 +: 8]          = clampUByte(opA[i*16 +: 16]);
    assign nub[HALF_W+i*8 +: 8]   = clampUByte(opB[i*16 +: 16]);
  end

  for (genvar i = 0; i < N_DWORD; i++) begin : g_dword
    assign nsw[i*16 +: 16]        = clampSWord(opA[i*32 +: 32]);
    assign nsw[HALF_W+i*16 +: 16] = clampSWord(opB[i*32 +: 32]);
  end

  for (genvar g = 0; g < N_GRAN; g++) begin : g_gran
    localparam int EW = 8 << g;
    localparam int NE = HALF_W / EW;
    for (genvar k = 0; k < NE; k++) begin : g_elem
      assign mixLo[g][(2*k)*EW +: EW]   = opA[k*EW +: EW];
      assign mixLo[g][(2*k+1)*EW +: EW] = opB[k*EW +: EW];
      assign mixHi[g][(2*k)*EW +: EW]   = opA[(NE+k)*EW +: EW];
      assign mixHi[g][(2*k+1)*EW +: EW] = opB[(NE+k)*EW +: EW];
    end
  end

  always_comb begin
    result = '0;
    case (stb.sel)
      SEL_NSB: result = nsb;
      SEL_NUB: result = nub;
      SEL_NSW: result = nsw;
      default: begin
        case (stb.gran)
          2'd0:    result = stb.mixHigh ? mixHi[0] : mixLo[0];
          2'd1:    result = stb.mixHigh ? mixHi[1] : mixLo[1];
          2'd2:    result = stb.mixHigh ? mixHi[2] : mixLo[2];
          default: result = '0;
        endcase
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      outData <= '0;
      outErr  <= 1'b0;
    end else if (stb.load) begin
      outData <= stb.bad ? '0 : result;
      outErr  <= stb.bad;
    end
  end

  // R9
  err_zero_chk: assert property (@(posedge clk) disable iff (rst)
    outErr |-> (outData == '0));

  // R8
  hold_data_chk: assert property (@(posedge clk) disable iff (rst)
    !stb.load |=> ($stable(outData) && $stable(outErr)));

  // R4
  mix_lo_byte_chk: assert property (@(posedge clk) disable iff (rst)
    (stb.load && !stb.bad && stb.sel == SEL_MIX && !stb.mixHigh && stb.gran == 2'd0)
      |=> (outData[15:8] == $past(opB[7:0]) && outData[7:0] == $past(opA[7:0])));

endmodule

// File: rtl/lane_mix_unit.sv
module lane_mix_unit
  import lane_mix_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  input  logic [3:0]        opCode,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  output logic              outValid,
  output logic [DATA_W-1:0] outData,
  output logic              outErr
);

  mixStrobe_t stb;

  lane_mix_ctrl i_ctrl (
    .clk      (clk),
    .rst      (rst),
    .inValid  (inValid),
    .opCode   (opCode),
    .stb      (stb),
    .outValid (outValid)
  );

  lane_mix_dp #(.DATA_W(DATA_W)) i_dp (
    .clk     (clk),
    .rst     (rst),
    .stb     (stb),
    .opA     (opA),
    .opB     (opB),
    .outData (outData),
    .outErr  (outErr)
  );

endmodule

// File: tb/test_lane_mix_unit.sv
module test_lane_mix_unit;

  logic        clk = 1'b0;
  logic        rst;
  logic        inValid;
  logic [3:0]  opCode;
  logic [63:0] opA;
  logic [63:0] opB;
  logic        outValid;
  logic [63:0] outData;
  logic        outErr;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  lane_mix_unit i_lane_mix_unit (
    .clk(clk), .rst(rst), .inValid(inValid), .opCode(opCode),
    .opA(opA), .opB(opB), .outValid(outValid), .outData(outData), .outErr(outErr)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] refModel(input logic [3:0] op, input logic [63:0] a,
                                           input logic [63:0] b);
    logic [63:0] r = '0;
    int ew;
    int base;
    case (op)
      4'd0, 4'd2: begin
        for (int i = 0; i < 4; i++) begin
          int va = $signed(a[i*16 +: 16]);
          int vb = $signed(b[i*16 +: 16]);
          int lo = (op == 4'd0) ? -128 : 0;
          int hi = (op == 4'd0) ? 127 : 255;
          if (va < lo) va = lo; if (va > hi) va = hi;
          if (vb < lo) vb = lo; if (vb > hi) vb = hi;
          r[i*8 +: 8]      = va[7:0];
          r[32+i*8 +: 8]   = vb[7:0];
        end
      end
      4'd1: begin
        for (int i = 0; i < 2; i++) begin
          longint va = $signed(a[i*32 +: 32]);
          longint vb = $signed(b[i*32 +: 32]);
          if (va < -32768) va = -32768; if (va > 32767) va = 32767;
          if (vb < -32768) vb = -32768; if (vb > 32767) vb = 32767;
          r[i*16 +: 16]    = va[15:0];
          r[32+i*16 +: 16] = vb[15:0];
        end
      end
      4'd4, 4'd5, 4'd6, 4'd8, 4'd9, 4'd10: begin
        ew = 8 << op[1:0];
        base = op[3] ? 32 / ew : 0;
        for (int k = 0; k < 32 / ew; k++)
          for (int j = 0; j < ew; j++) begin
            r[(2*k)*ew + j]   = a[(base+k)*ew + j];
            r[(2*k+1)*ew + j] = b[(base+k)*ew + j];
          end
      end
      default: r = '0;
    endcase
    return r;
  endfunction

  task automatic runOp(input string req, input logic [3:0] op, input logic [63:0] a,
                       input logic [63:0] b);
    logic expErr = !(op inside {4'd0, 4'd1, 4'd2, 4'd4, 4'd5, 4'd6, 4'd8, 4'd9, 4'd10});
    @(negedge clk);
    inValid = 1'b1; opCode = op; opA = a; opB = b;
    @(negedge clk);
    inValid = 1'b0;
    chk({req, " valid"}, {63'd0, outValid}, 64'd1);
    chk({req, " data"}, outData, refModel(op, a, b));
    chk({req, " err"}, {63'd0, outErr}, {63'd0, expErr});
  endtask

  task automatic tReset();
    rst = 1'b1; inValid = 1'b0; opCode = '0; opA = '0; opB = '0;
    repeat (3) @(negedge clk);
    chk("R10 reset valid", {63'd0, outValid}, 64'd0);
    chk("R10 reset data", outData, 64'd0);
    chk("R10 reset err", {63'd0, outErr}, 64'd0);
    rst = 1'b0;
  endtask

  task automatic tNarrowSigned();
    runOp("R1 clamp", 4'd0, 64'h7fff_8000_0080_ff7f, 64'hff80_007f_0050_fffe);
    runOp("R1 mixed", 4'd0, 64'h1234_fe00_0001_0000, 64'h00ff_ff00_8001_7ffe);
    chk("R1 literal", refModel(4'd0, 64'h0100_ff00_0005_fff0, 64'h0), 64'h0000_0000_7f80_05f0);
  endtask

  task automatic tNarrowDword();
    runOp("R2 clamp", 4'd1, 64'h0001_0000_ffff_0000, 64'h0000_7fff_ffff_8000);
    runOp("R2 inrange", 4'd1, 64'h0000_1234_ffff_f000, 64'h8000_0000_7fff_ffff);
  endtask

  task automatic tNarrowUns();
    runOp("R3 literal", 4'd2, 64'h0100_ffff_0080_0005, 64'h0);
    chk("R3 literal exact", outData, 64'h0000_0000_ff00_8005);
    runOp("R3 mixed", 4'd2, 64'h00ff_8000_7fff_0000, 64'h0001_0100_ffff_00fe);
  endtask

  task automatic tMixLow();
    runOp("R4 bytes", 4'd4, 64'h8877_6655_4433_2211, 64'hffee_ddcc_bbaa_9988);
    chk("R4 exact", outData, 64'hbb44_aa33_9922_8811);
    runOp("R5 words", 4'd5, 64'h8877_6655_4433_2211, 64'hffee_ddcc_bbaa_9988);
    chk("R5 words exact", outData, 64'hbbaa_4433_9988_2211);
    runOp("R5 dwords", 4'd6, 64'h8877_6655_4433_2211, 64'hffee_ddcc_bbaa_9988);
  endtask

  task automatic tMixHigh();
    runOp("R6 bytes", 4'd8, 64'h8877_6655_4433_2211, 64'hffee_ddcc_bbaa_9988);
    chk("R6 bytes exact", outData, 64'hff88_ee77_dd66_cc55);
    runOp("R6 words", 4'd9, 64'h0123_4567_89ab_cdef, 64'hfedc_ba98_7654_3210);
    runOp("R6 dwords", 4'd10, 64'h0123_4567_89ab_cdef, 64'hfedc_ba98_7654_3210);
    chk("R6 dwords exact", outData, 64'hfedc_ba98_0123_4567);
  endtask

  task automatic tBadOp();
    runOp("R9 code3", 4'd3, 64'hdead_beef_dead_beef, 64'h1);
    runOp("R9 code15", 4'd15, 64'h5555_5555_5555_5555, 64'haaaa);
    runOp("R9 recover", 4'd4, 64'h1, 64'h2);
  endtask

  task automatic tHold();
    logic [63:0] kept;
    runOp("R7 capture", 4'd5, 64'h1111_2222_3333_4444, 64'h5555_6666_7777_8888);
    kept = outData;
    opA = 64'hffff_ffff_ffff_ffff; opB = 64'h0; opCode = 4'd7;
    repeat (2) @(negedge clk);
    chk("R8 hold data", outData, kept);
    chk("R8 hold err", {63'd0, outErr}, 64'd0);
    chk("R7 idle valid", {63'd0, outValid}, 64'd0);
  endtask

  initial begin
    tReset();
    tNarrowSigned();
    tNarrowDword();
    tNarrowUns();
    tMixLow();
    tMixHigh();
    tBadOp();
    tHold();
    repeat (2) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual timeout expected finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule